// File: doc/BRIEF.md
# Double-Length Accumulator Shifter

This block holds a 64-bit operand made of two 32-bit halves. The accumulator A is the upper half and the register R is the lower half. It shifts that operand one bit per clock. A start pulse loads both halves, a direction select and a 6-bit count field. The block then steps until the count, which climbs by one each step, wraps back to zero. It presents the new A and R together with a one-cycle done pulse.

The count is an up-counter, and the two directions encode the amount differently. For a left command the field is the rotation amount n. Each step rotates the pair right by one place, so 64 − n steps give a net left rotation by n. For a right command the field holds 64 − n, and each of the n steps is an arithmetic right shift of the pair. With each start the block also reports how many word cycles a sequencer should wait after the operation. That figure depends only on the top bit of the count field.

Top module: `dlen_shifter`

## Requirements
- R1: After a synchronous reset, `acc_out` and `reg_out` are 0, `busy` and `done` are 0, and `post_delay` is 0.
- R2: A `start` pulse while `busy` is 0 is accepted. It loads `acc_in`, `reg_in`, `dir` and `count` on that clock edge.
- R3: With `dir` = 0 (left) and `count` = n in 1..63, the final {A,R} equals the loaded 64-bit value rotated left by n. Bit 0 of R re-enters at bit 31 of A at each step.
- R4: With `dir` = 1 (right) and `count` = c in 1..63, the final {A,R} equals the loaded value arithmetically shifted right by 64 − c. Bit 31 of A fills the vacated bits, and bit 0 of A moves into bit 31 of R.
- R5: A `count` of 0 performs no step in either direction. A and R keep the loaded values.
- R6: The block takes one step per clock. `done` is high in the cycle after the k-th clock edge following the accepting edge, where k = (64 − count) mod 64.
- R7: `done` is high for exactly one cycle when no new start follows it.
- R8: `post_delay` becomes 1 when bit 5 of the accepted `count` is 1, and 2 otherwise. It holds that value until the next accepted start.
- R9: A `start` that arrives while `busy` is 1 has no effect on the result, the timing or `post_delay` of the running operation.
- R10: `busy` is high from the accepting edge of a nonzero count until the edge that raises `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation when idle |
| dir | input | 1 | 0 = rotate left, 1 = arithmetic shift right |
| count | input | 6 | Count field (n for left, 64 − n for right) |
| acc_in | input | 32 | Value loaded into A at start |
| reg_in | input | 32 | Value loaded into R at start |
| acc_out | output | 32 | Accumulator A |
| reg_out | output | 32 | Register R |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| post_delay | output | 2 | Post-operation delay in word cycles |

## Verification
The accepting edge loads the operands and `post_delay`. For a nonzero count, `done` and the final A and R appear exactly (64 − count) edges later. For a zero count they appear on the accepting edge itself. The bench drives and samples on the falling edge. After the start edge it counts falling edges until `done` is seen and compares that count with the expected step count. It reads A, R and `post_delay` in that same cycle and confirms on the next falling edge that `done` has dropped.

// File: rtl/dlsh_pkg.sv
package dlsh_pkg;

  typedef enum logic {
    SH_ROT_LEFT    = 1'b0,
    SH_ARITH_RIGHT = 1'b1
  } sh_dir_e;

  localparam int unsigned DLY_FAST = 1;
  localparam int unsigned DLY_SLOW = 2;

endpackage

// File: rtl/dlsh_ctrl.sv
module dlsh_ctrl
  import dlsh_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  sh_dir_e          dir_in,
  input  logic [CNT_W-1:0] cnt_in,
  output logic             load,
  output logic             step,
  output sh_dir_e          dir_q,
  output logic             busy,
  output logic             done
);

  localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             done_q;

  assign load = start && !busy_q;
  assign step = busy_q;
  assign busy = busy_q;
  assign done = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= CNT_ZERO;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      dir_q  <= SH_ROT_LEFT;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        cnt_q <= cnt_in;
        dir_q <= dir_in;
        if (cnt_in == CNT_ZERO) done_q <= 1'b1;
        else                    busy_q <= 1'b1;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  // R6: counter advances by one per busy cycle
  assert_cnt_step_R6: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cnt_q != CNT_LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R10: last step ends busy and raises done
  assert_finish_R10: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cnt_q == CNT_LAST) |=> (done_q && !busy_q));

  // R9: a start during a run does not alter the latched direction
  assert_ignore_start_R9: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start) |=> (dir_q == $past(dir_q)));

  // R7: done and busy never overlap
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q);

endmodule

// File: rtl/dlsh_datapath.sv
module dlsh_datapath
  import dlsh_pkg::*;
#(
  parameter int unsigned HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  sh_dir_e           dir_q,
  input  logic [HALF_W-1:0] acc_in,
  input  logic [HALF_W-1:0] reg_in,
  output logic [HALF_W-1:0] acc_q,
  output logic [HALF_W-1:0] reg_q
);

  localparam int unsigned MSB = HALF_W - 1;

  logic top_fill;

  // Vacated A bit: R's low bit for a rotate, A's sign for an arithmetic shift
  always_comb begin
    if (dir_q == SH_ARITH_RIGHT) top_fill = acc_q[MSB];
    else                         top_fill = reg_q[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      reg_q <= '0;
    end else if (load) begin
      acc_q <= acc_in;
      reg_q <= reg_in;
    end else if (step) begin
      acc_q <= {top_fill, acc_q[MSB:1]};
      reg_q <= {acc_q[0], reg_q[MSB:1]};
    end
  end

  // R4: arithmetic right step keeps the sign of A
  assert_sign_keep_R4: assert property (@(posedge clk) disable iff (rst)
    (step && !load && dir_q == SH_ARITH_RIGHT) |=> (acc_q[MSB] == $past(acc_q[MSB])));

  // R3: rotate step preserves the number of ones in the pair
  assert_rot_ones_R3: assert property (@(posedge clk) disable iff (rst)
    (step && !load && dir_q == SH_ROT_LEFT)
      |=> ($countones({acc_q, reg_q}) == $past($countones({acc_q, reg_q}))));

  // R5: without load or step the pair holds
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> ($stable(acc_q) && $stable(reg_q)));

endmodule

// File: rtl/dlsh_delay.sv
module dlsh_delay
  import dlsh_pkg::*;
#(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned DLY_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] cnt_in,
  output logic [DLY_W-1:0] dly_q
);

  localparam logic [DLY_W-1:0] FAST_V = DLY_W'(DLY_FAST);
  localparam logic [DLY_W-1:0] SLOW_V = DLY_W'(DLY_SLOW);

  always_ff @(posedge clk) begin
    if (rst)       dly_q <= '0;
    else if (load) dly_q <= cnt_in[CNT_W-1] ? FAST_V : SLOW_V;
  end

  // R8: the figure only changes on an accepted start
  assert_dly_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(dly_q));

endmodule

// File: rtl/dlen_shifter.sv
module dlen_shifter
  import dlsh_pkg::*;
#(
  parameter int unsigned HALF_W = 32,
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned DLY_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              dir,
  input  logic [CNT_W-1:0]  count,
  input  logic [HALF_W-1:0] acc_in,
  input  logic [HALF_W-1:0] reg_in,
  output logic [HALF_W-1:0] acc_out,
  output logic [HALF_W-1:0] reg_out,
  output logic              busy,
  output logic              done,
  output logic [DLY_W-1:0]  post_delay
);

  logic    load;
  logic    step;
  sh_dir_e dir_q;
  sh_dir_e dir_e;

  assign dir_e = sh_dir_e'(dir);

  dlsh_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .dir_in (dir_e),
    .cnt_in (count),
    .load   (load),
    .step   (step),
    .dir_q  (dir_q),
    .busy   (busy),
    .done   (done)
  );

  dlsh_datapath #(.HALF_W(HALF_W)) u_path (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .step   (step),
    .dir_q  (dir_q),
    .acc_in (acc_in),
    .reg_in (reg_in),
    .acc_q  (acc_out),
    .reg_q  (reg_out)
  );

  dlsh_delay #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_dly (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .cnt_in (count),
    .dly_q  (post_delay)
  );

  // R2: a start while idle with a zero count finishes on the next edge
  assert_zero_done_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && count == '0) |=> (done && !busy));

endmodule

// File: tb/dlen_shifter_tb.sv
module dlen_shifter_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        dir = 1'b0;
  logic [5:0]  count = '0;
  logic [31:0] acc_in = '0;
  logic [31:0] reg_in = '0;
  logic [31:0] acc_out;
  logic [31:0] reg_out;
  logic        busy;
  logic        done;
  logic [1:0]  post_delay;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dlen_shifter u_dut (
    .clk(clk), .rst(rst), .start(start), .dir(dir), .count(count),
    .acc_in(acc_in), .reg_in(reg_in), .acc_out(acc_out), .reg_out(reg_out),
    .busy(busy), .done(done), .post_delay(post_delay)
  );

  // {dir, count, A, R}
  localparam int NV = 10;
  localparam logic [70:0] VECS [NV] = '{
    {1'b0, 6'd1,  32'h8000_0001, 32'h0000_0003},
    {1'b0, 6'd32, 32'h1234_5678, 32'h9ABC_DEF0},
    {1'b0, 6'd63, 32'hF000_000F, 32'h0000_0001},
    {1'b0, 6'd4,  32'hDEAD_BEEF, 32'h0123_4567},
    {1'b1, 6'd63, 32'h8000_0002, 32'h0000_0001},
    {1'b1, 6'd32, 32'hC000_1234, 32'h5555_AAAA},
    {1'b1, 6'd1,  32'h7FFF_FFFF, 32'hFFFF_FFFF},
    {1'b1, 6'd40, 32'h89AB_CDEF, 32'h1357_9BDF},
    {1'b0, 6'd0,  32'hCAFE_F00D, 32'h0BAD_BEEF},
    {1'b1, 6'd0,  32'h8765_4321, 32'h1111_2222}
  };

  function automatic logic [63:0] model(logic d, logic [5:0] c, logic [63:0] x);
    int n;
    if (c == 6'd0) return x;
    if (!d) begin
      n = int'(c);
      return (x << n) | (x >> (64 - n));
    end
    n = 64 - int'(c);
    return 64'($signed(x) >>> n);
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_start(logic d, logic [5:0] c, logic [31:0] a, logic [31:0] r);
    @(negedge clk);
    dir = d; count = c; acc_in = a; reg_in = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Waits for done after the accepting edge; returns falling edges counted
  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic run_vec(logic d, logic [5:0] c, logic [31:0] a, logic [31:0] r, string tag);
    int cyc;
    int steps;
    logic [63:0] exp;
    steps = (64 - int'(c)) % 64;
    exp = model(d, c, {a, r});
    pulse_start(d, c, a, r);
    check(c == 6'd0 || busy, "R10 busy after start", 64'(busy), 64'd1);
    wait_done(cyc);
    check(cyc == steps, {"R6 done timing ", tag}, 64'(cyc), 64'(steps));
    check({acc_out, reg_out} == exp, {tag, " result"}, {acc_out, reg_out}, exp);
    check(post_delay == (c[5] ? 2'd1 : 2'd2), "R8 post_delay",
          64'(post_delay), c[5] ? 64'd1 : 64'd2);
    @(negedge clk);
    check(!done, "R7 done single cycle", 64'(done), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog R6 actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(acc_out == 0 && reg_out == 0, "R1 reset A/R", {acc_out, reg_out}, 64'd0);
    check(!busy && !done && post_delay == 0, "R1 reset flags",
          {61'd0, busy, done, 1'b0} | 64'(post_delay), 64'd0);

    for (int i = 0; i < NV; i++) begin
      logic [70:0] v;
      v = VECS[i];
      run_vec(v[70], v[69:64], v[63:32], v[31:0],
              v[69:64] == 0 ? "R5" : (v[70] ? "R4" : "R3"));
    end

    // R2: load values visible after zero-count start
    run_vec(1'b0, 6'd0, 32'h0000_0000, 32'hFFFF_FFFF, "R2");

    // R9: start during a run is ignored
    begin
      int cyc;
      logic [63:0] exp;
      exp = model(1'b0, 6'd1, {32'h0000_0001, 32'h8000_0000});
      pulse_start(1'b0, 6'd1, 32'h0000_0001, 32'h8000_0000);
      repeat (10) @(negedge clk);
      dir = 1'b1; count = 6'd40; acc_in = 32'hFFFF_FFFF; reg_in = 32'h1234_5678;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy, "R9 still busy", 64'(busy), 64'd1);
      wait_done(cyc);
      check(cyc == 63 - 11, "R9 timing unchanged", 64'(cyc), 64'(63 - 11));
      check({acc_out, reg_out} == exp, "R9 result unchanged", {acc_out, reg_out}, exp);
      check(post_delay == 2'd2, "R9 post_delay unchanged", 64'(post_delay), 64'd2);
    end

    // R1: reset mid-run clears state
    pulse_start(1'b1, 6'd10, 32'h8000_0000, 32'h1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(!busy && acc_out == 0 && reg_out == 0, "R1 reset mid-run",
          {acc_out, reg_out}, 64'd0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule